// File: doc/BRIEF.md
# Serial Result Shifter with Tag Chaining

This block moves a finished 12-bit conversion result out over a single serial data line. The line is paced by an external data clock rather than by the block's own clock. The external clock, the chip-select, the read enable and the tag input are all taken to be synchronous to the system clock `clk`. The data clock is sampled every `clk` cycle and has to stay at each level for at least two `clk` cycles. Every rising edge of the data clock that arrives while shifting is enabled advances the frame by one step.

At the start of each frame a one-period sync pulse goes out, then the result word, most significant bit first. After the word the output keeps going with the bits taken in on the tag input. This lets one device's output feed the tag input of the next, so several devices can be read as one chain.

The result arrives on a valid-only stream input. The block takes a word in every cycle in which `res_valid` is high and applies no back-pressure, so there is no ready signal. A word that arrives while a frame is being read still replaces the frame's contents. When that happens while the data clock is high, the block reports the lost read on `load_lost`.

Top module: `result_serializer`

## Requirements
- R1: `sdo_oe` is high exactly while `cs_n` is low and `rd_en` is high, in the same cycle as those inputs, and low otherwise. When it is low the serial output counts as high-impedance.
- R2: On the first enabled rising data-clock edge of a frame, `sync` goes high one `clk` cycle after the edge is sampled. It goes low in the same way after the second enabled rising edge, so it stays high for exactly one data-clock period.
- R3: Starting from the second enabled rising edge, each enabled rising edge puts the next bit of the loaded word on `sdo`, most significant bit first. The least significant bit appears after edge 13.
- R4: The tag bit sampled on enabled rising edge j appears on `sdo` after edge j+13. Tag bits keep flowing for as long as enabled edges continue and no new word is loaded.
- R5: A cycle with `res_valid` high loads `res_data`, clears `sync` and restarts the frame, so the next enabled edge is edge 1. A data-clock edge sampled in the same cycle as the load is ignored.
- R6: While `cs_n` is high the frame restarts, and `sync` is cleared, but the shifted contents are kept. After reselection the next enabled edge acts as edge 1: it raises `sync` and shifts nothing.
- R7: `load_lost` pulses high for one cycle, one cycle after a load that arrives while `cs_n` is low, `rd_en` is high and `sclk` is high. It stays low in every other case.
- R8: Rising data-clock edges that arrive while `rd_en` is low do not change `sdo`, do not change `sync` and do not advance the frame.
- R9: After reset, `sdo`, `sync` and `load_lost` are low and the frame is at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_data | input | 12 | Result word to serialize |
| res_valid | input | 1 | Load strobe; takes `res_data` in, no back-pressure |
| cs_n | input | 1 | Active-low chip select |
| rd_en | input | 1 | Read enable (high = read) |
| sclk | input | 1 | External data clock, sampled by `clk` |
| tag_in | input | 1 | Chained serial input appended after the word |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for `sdo` |
| sync | output | 1 | Frame sync pulse |
| load_lost | output | 1 | Flags a load that corrupted a read |

## Verification
A wrong frame count shows up at the ports as a sync pulse on the wrong edge. Because every later bit depends on that count, the whole stream then sits one position off, and this is visible within one data-clock period. A fault in the shift path or the tag delay slot puts a wrong bit on `sdo` at the edge where that bit emerges. For the word this happens within 13 edges of a load; a tag bit emerges 13 edges after it was sampled. A reference model compares `sdo`, `sync`, `sdo_oe` and `load_lost` on every cycle, so a difference is reported on the cycle after the edge that causes it.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned RES_W = 12;
  localparam int unsigned LEAD_EDGES = 1;
endpackage

// File: rtl/rs_edge_det.sv
module rs_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/rs_frame_ctl.sv
module rs_frame_ctl #(
  parameter int unsigned LEAD = rs_pkg::LEAD_EDGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic restart,
  output logic sync,
  output logic shift_en
);
  localparam int unsigned CNT_W = $clog2(LEAD + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LEAD);

  logic [CNT_W-1:0] cnt;

  assign shift_en = step & (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sync <= 1'b0;
    end else if (restart) begin
      cnt  <= '0;
      sync <= 1'b0;
    end else if (step) begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      sync <= (cnt == '0);
    end
  end
endmodule

// File: rtl/rs_shifter.sv
module rs_shifter #(
  parameter int unsigned W = rs_pkg::RES_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         sample,
  input  logic         shift,
  input  logic         tag_in,
  output logic         sdo
);
  logic [W-1:0] sr;
  logic         tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      tag_q <= 1'b0;
      sdo   <= 1'b0;
    end else if (load) begin
      sr <= load_data;
    end else begin
      if (shift) begin
        sdo <= sr[W-1];
        sr  <= {sr[W-2:0], tag_q};
      end
      if (sample) tag_q <= tag_in;
    end
  end
endmodule

// File: rtl/result_serializer.sv
module result_serializer #(
  parameter int unsigned W = rs_pkg::RES_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] res_data,
  input  logic         res_valid,
  input  logic         cs_n,
  input  logic         rd_en,
  input  logic         sclk,
  input  logic         tag_in,
  output logic         sdo,
  output logic         sdo_oe,
  output logic         sync,
  output logic         load_lost
);
  logic rise;
  logic active;
  logic step;
  logic shift_en;

  assign active = ~cs_n & rd_en;
  assign sdo_oe = active;
  assign step   = rise & active & ~res_valid;

  rs_edge_det u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (sclk),
    .rise (rise)
  );

  rs_frame_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .restart (res_valid | cs_n),
    .sync    (sync),
    .shift_en(shift_en)
  );

  rs_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (res_valid),
    .load_data(res_data),
    .sample   (step),
    .shift    (shift_en),
    .tag_in   (tag_in),
    .sdo      (sdo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_lost <= 1'b0;
    else        load_lost <= res_valid & active & sclk;
  end
endmodule

// File: rtl/result_serializer_chk.sv
module result_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic res_valid,
  input logic cs_n,
  input logic rd_en,
  input logic sdo,
  input logic sync,
  input logic load_lost,
  input logic rise,
  input logic step
);
  // R2
  sync_one_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && step) |=> !sync);
  // R2
  sync_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> $past(rise));
  // R5
  load_clears_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !sync);
  // R6
  deselect_clears_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sync);
  // R7
  lost_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_lost |-> $past(res_valid));
  // R8
  idle_sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && rd_en) |=> $stable(sdo));
endmodule

bind result_serializer result_serializer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .res_valid(res_valid),
  .cs_n     (cs_n),
  .rd_en    (rd_en),
  .sdo      (sdo),
  .sync     (sync),
  .load_lost(load_lost),
  .rise     (rise),
  .step     (step)
);

// File: tb/result_serializer_tb.sv
module result_serializer_tb;
  localparam int CLK_P = 10;
  localparam int W = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic [W-1:0] res_data = '0;
  logic res_valid = 0, cs_n = 1, rd_en = 0, sclk = 0, tag_in = 0;
  logic sdo, sdo_oe, sync, load_lost;

  result_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
    .cs_n(cs_n), .rd_en(rd_en), .sclk(sclk), .tag_in(tag_in),
    .sdo(sdo), .sdo_oe(sdo_oe), .sync(sync), .load_lost(load_lost)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string phase = "R9";

  // behavioural reference
  bit q[$];
  bit pend = 0;
  int edge_no = 0;
  bit m_sdo = 0, m_sync = 0, m_lost = 0, m_sclk_prev = 0;

  task automatic cmp(string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", phase, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit en, rose;
    cycles++;
    en = !cs_n && rd_en;
    rose = sclk && !m_sclk_prev;
    if (!rst_n) begin
      q = {}; for (int i = 0; i < W; i++) q.push_back(1'b0);
      pend = 0; edge_no = 0; m_sdo = 0; m_sync = 0; m_lost = 0; m_sclk_prev = 0;
    end else begin
      m_lost = res_valid && en && sclk;
      if (res_valid) begin
        q = {}; for (int i = W-1; i >= 0; i--) q.push_back(res_data[i]);
        edge_no = 0; m_sync = 0;
      end else if (cs_n) begin
        edge_no = 0; m_sync = 0;
      end else if (en && rose) begin
        edge_no++;
        if (edge_no == 1) m_sync = 1;
        else begin
          m_sync = 0;
          m_sdo = q.pop_front();
          q.push_back(pend);
        end
        pend = tag_in;
      end
      m_sclk_prev = sclk;
    end
    #(CLK_P/4);
    cmp("sdo_oe (R1)", sdo_oe, !cs_n && rd_en);
    cmp("sync (R2)", sync, m_sync);
    cmp("load_lost (R7)", load_lost, m_lost);
    if (sdo_oe) cmp("sdo (R3 R4)", sdo, m_sdo);
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic data_clocks(int n, bit rnd_tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk = 1; tag_in = rnd_tag ? 1'($urandom) : ~tag_in;
      wait_clk(2); sclk = 0;
      wait_clk(1);
    end
  endtask

  task automatic load(logic [W-1:0] d);
    @(negedge clk); res_data = d; res_valid = 1;
    @(negedge clk); res_valid = 0;
  endtask

  initial begin
    phase = "R9";
    wait_clk(4);
    rst_n = 1;
    wait_clk(2);
    phase = "R1";
    cs_n = 0; rd_en = 1; wait_clk(2);
    rd_en = 0; wait_clk(2);
    // R3 R2 R4: full frame then tag stream
    phase = "R3";
    load(12'hA5C);
    rd_en = 1;
    data_clocks(14, 1);
    phase = "R4";
    data_clocks(20, 1);
    // R5: new load restarts, with edge in same cycle
    phase = "R5";
    @(negedge clk); sclk = 0;
    @(negedge clk); res_data = 12'h3F1; res_valid = 1; sclk = 1;
    @(negedge clk); res_valid = 0;
    wait_clk(1); sclk = 0; wait_clk(2);
    data_clocks(16, 1);
    // R7: load while clock high and selected
    phase = "R7";
    @(negedge clk); sclk = 1;
    @(negedge clk); res_data = 12'h0F0; res_valid = 1;
    @(negedge clk); res_valid = 0;
    @(negedge clk); sclk = 0; wait_clk(2);
    data_clocks(6, 0);
    // R7 negative: load with clock high but deselected
    @(negedge clk); cs_n = 1; sclk = 1;
    @(negedge clk); res_data = 12'hFFF; res_valid = 1;
    @(negedge clk); res_valid = 0; sclk = 0;
    wait_clk(2);
    // R6: reselect mid-frame
    phase = "R6";
    cs_n = 0;
    data_clocks(5, 1);
    @(negedge clk); cs_n = 1; wait_clk(3);
    @(negedge clk); cs_n = 0;
    data_clocks(18, 1);
    // R8: edges with read disabled
    phase = "R8";
    @(negedge clk); rd_en = 0;
    data_clocks(6, 1);
    @(negedge clk); rd_en = 1;
    data_clocks(10, 1);
    phase = "R9";
    @(negedge clk); rst_n = 0; wait_clk(3);
    rst_n = 1; wait_clk(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule